// File: doc/BRIEF.md
# Processor Doorbell Message Unit

This block turns doorbell message operations into per-processor interrupt-request updates. A send operation carries a 32-bit operand word. The unit decodes a message type from that word and works out which processors the message targets. Each of `NPROC` processors has its own ID, and a target matches when that ID equals the tag field of the operand. Every targeted processor gets a set mask that raises one pending doorbell bit, plus a one-cycle hard-interrupt request strobe.

A clear operation decodes the type the same way. It produces a clear mask for the issuing processor alone.

Two decoding flavours are selected by an input:
- The embedded flavour knows a normal doorbell and a critical doorbell. It supports a broadcast bit and matches 14-bit tags.
- The server flavour knows only a hypervisor doorbell. It matches 20-bit tags exactly and has no broadcast.

Any type that maps to no doorbell leaves every output quiet. Interrupt delivery and priority stay with the consumers of the masks.

Top module: `dbell_msg_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `set_mask`, `clr_mask` and `hirq` are all zero.
- R2: In the embedded flavour (`flavour`=0), type 0 in operand bits [31:27] selects the normal doorbell, which is pending bit 0 of a processor slot. Type 1 selects the critical doorbell, which is pending bit 1. Processor p owns bits [3p+2:3p] of each mask.
- R3: In the embedded flavour, types 2, 3 and 4 (guest doorbell, guest critical, guest machine-check) and every type from 5 to 31 are no-ops: no mask bit and no strobe.
- R4: In the server flavour (`flavour`=1), only type 5 is valid, and it selects the hypervisor doorbell, which is pending bit 2. Every other type is a no-op.
- R5: In the embedded flavour, a send targets each processor whose ID bits [13:0] equal operand bits [13:0]. If operand bit 26 (broadcast) is 1, it targets every processor. ID and operand bits above 13 are ignored.
- R6: In the server flavour, a send targets only processors whose 20-bit ID equals operand bits [19:0]. Bit 26 has no effect.
- R7: A clear sets, in `clr_mask`, only the decoded bit of the slot named by `clr_cpu`. A clear never raises `hirq`.
- R8: `hirq[p]` is 1 exactly when processor p has a set bit from a valid send.
- R9: Outputs appear in the cycle after the operation strobe and last one cycle. With no strobe, the outputs are zero.
- R10: When a send and a clear hit the same bit in the same cycle, the set wins and that clear bit is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flavour | input | 1 | 0 embedded decoding, 1 server decoding |
| snd_vld | input | 1 | Send operation strobe |
| snd_word | input | 32 | Send operand |
| clr_vld | input | 1 | Clear operation strobe |
| clr_word | input | 32 | Clear operand |
| clr_cpu | input | CPU_W | Index of the processor issuing the clear |
| proc_ids | input | NPROC*20 | Processor IDs, ID p in bits [20p+19:20p] |
| set_mask | output | NPROC*3 | Pending bits to set, 3 per processor |
| clr_mask | output | NPROC*3 | Pending bits to clear, 3 per processor |
| hirq | output | NPROC | Hard-interrupt request strobes |

## Verification
The checker watches several properties on every cycle:
- set and clear masks never overlap;
- each slot sets at most one bit;
- the strobe agrees with the slot's set bits;
- a bit outside the flavour's doorbell set never rises;
- a clear touches at most one bit;
- outputs are quiet in any cycle after one without a strobe.

Whether the right type was picked, whether the right processors were targeted, whether bits above the tag field were ignored, and which slot a clear reaches all depend on operand values. Only the bench shows these. It sweeps every type, the broadcast bit and a set of tags in both flavours, and checks each result against IDs chosen to alias in 14 bits but differ in 20.

// File: rtl/dbell_pkg.sv
package dbell_pkg;
  localparam int WORD_W    = 32;
  localparam int TYPE_LSB  = 27;
  localparam int TYPE_W    = 5;
  localparam int BCAST_BIT = 26;
  localparam int EMB_TAG_W = 14;
  localparam int ID_W      = 20;
  localparam int KIND_W    = 3;

  localparam int KIND_NORM = 0;
  localparam int KIND_CRIT = 1;
  localparam int KIND_HYP  = 2;

  localparam logic [TYPE_W-1:0] EMB_T_NORM = 5'd0;
  localparam logic [TYPE_W-1:0] EMB_T_CRIT = 5'd1;
  localparam logic [TYPE_W-1:0] SRV_T_HYP  = 5'd5;

  // Type code to one-hot doorbell kind; zero means no-op.
  function automatic logic [KIND_W-1:0] decode_kind(input logic [TYPE_W-1:0] typ,
                                                    input logic srv);
    logic [KIND_W-1:0] k;
    k = '0;
    if (srv) begin
      if (typ == SRV_T_HYP) k[KIND_HYP] = 1'b1;
    end else begin
      if (typ == EMB_T_NORM) k[KIND_NORM] = 1'b1;
      if (typ == EMB_T_CRIT) k[KIND_CRIT] = 1'b1;
    end
    return k;
  endfunction

  // Whether a message operand targets a processor with the given ID.
  function automatic logic tag_match(input logic [WORD_W-1:0] word,
                                     input logic [ID_W-1:0] id,
                                     input logic srv);
    if (srv) return word[ID_W-1:0] == id;
    return word[BCAST_BIT] || (word[EMB_TAG_W-1:0] == id[EMB_TAG_W-1:0]);
  endfunction
endpackage

// File: rtl/dbell_type_decode.sv
module dbell_type_decode
  import dbell_pkg::*;
(
  input  logic              en,
  input  logic [WORD_W-1:0] word,
  input  logic              srv,
  output logic [KIND_W-1:0] kind
);
  assign kind = en ? decode_kind(word[TYPE_LSB +: TYPE_W], srv) : '0;
endmodule

// File: rtl/dbell_tag_match.sv
module dbell_tag_match
  import dbell_pkg::*;
#(
  parameter int NPROC = 4
) (
  input  logic                  srv,
  input  logic [WORD_W-1:0]     word,
  input  logic [NPROC*ID_W-1:0] ids,
  output logic [NPROC-1:0]      hit
);
  for (genvar p = 0; p < NPROC; p++) begin : g_cmp
    assign hit[p] = tag_match(word, ids[p*ID_W +: ID_W], srv);
  end
endmodule

// File: rtl/dbell_msg_unit.sv
module dbell_msg_unit
  import dbell_pkg::*;
#(
  parameter int NPROC = 4,
  localparam int CPU_W = (NPROC > 1) ? $clog2(NPROC) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    flavour,
  input  logic                    snd_vld,
  input  logic [WORD_W-1:0]       snd_word,
  input  logic                    clr_vld,
  input  logic [WORD_W-1:0]       clr_word,
  input  logic [CPU_W-1:0]        clr_cpu,
  input  logic [NPROC*ID_W-1:0]   proc_ids,
  output logic [NPROC*KIND_W-1:0] set_mask,
  output logic [NPROC*KIND_W-1:0] clr_mask,
  output logic [NPROC-1:0]        hirq
);
  logic [KIND_W-1:0]       snd_kind;
  logic [KIND_W-1:0]       clr_kind;
  logic [NPROC-1:0]        snd_hit;
  logic [NPROC*KIND_W-1:0] set_nxt;
  logic [NPROC*KIND_W-1:0] clr_nxt;
  logic [NPROC-1:0]        irq_nxt;

  dbell_type_decode u_snd_dec (.en(snd_vld), .word(snd_word), .srv(flavour), .kind(snd_kind));
  dbell_type_decode u_clr_dec (.en(clr_vld), .word(clr_word), .srv(flavour), .kind(clr_kind));

  dbell_tag_match #(.NPROC(NPROC)) u_match (
    .srv(flavour), .word(snd_word), .ids(proc_ids), .hit(snd_hit)
  );

  always_comb begin
    for (int p = 0; p < NPROC; p++) begin
      set_nxt[p*KIND_W +: KIND_W] = snd_hit[p] ? snd_kind : '0;
      clr_nxt[p*KIND_W +: KIND_W] = (clr_cpu == CPU_W'(p))
                                  ? (clr_kind & ~set_nxt[p*KIND_W +: KIND_W]) : '0;
      irq_nxt[p] = snd_hit[p] && (snd_kind != '0);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      set_mask <= '0;
      clr_mask <= '0;
      hirq     <= '0;
    end else begin
      set_mask <= set_nxt;
      clr_mask <= clr_nxt;
      hirq     <= irq_nxt;
    end
  end
endmodule

// File: rtl/dbell_msg_unit_chk.sv
module dbell_msg_unit_chk
  import dbell_pkg::*;
#(
  parameter int NPROC = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    flavour,
  input logic                    snd_vld,
  input logic                    clr_vld,
  input logic [NPROC*KIND_W-1:0] set_mask,
  input logic [NPROC*KIND_W-1:0] clr_mask,
  input logic [NPROC-1:0]        hirq
);
  assert_set_beats_clr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (set_mask & clr_mask) == '0);

  assert_clr_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(clr_mask) <= 1);

  assert_idle_send_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !snd_vld |=> (set_mask == '0 && hirq == '0));

  assert_idle_clr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_vld |=> clr_mask == '0);

  assert_no_irq_on_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !snd_vld |=> hirq == '0);

  for (genvar p = 0; p < NPROC; p++) begin : g_slot
    assert_irq_follows_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
      hirq[p] == (set_mask[p*KIND_W +: KIND_W] != '0));

    assert_one_kind_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(set_mask[p*KIND_W +: KIND_W]));

    assert_srv_kinds_R4: assert property (@(posedge clk) disable iff (!rst_n)
      flavour |=> (set_mask[p*KIND_W +: 2] == '0 && clr_mask[p*KIND_W +: 2] == '0));

    assert_emb_kinds_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !flavour |=> (!set_mask[p*KIND_W + KIND_HYP] && !clr_mask[p*KIND_W + KIND_HYP]));
  end
endmodule

bind dbell_msg_unit dbell_msg_unit_chk #(.NPROC(NPROC)) u_chk (
  .clk(clk), .rst_n(rst_n), .flavour(flavour), .snd_vld(snd_vld), .clr_vld(clr_vld),
  .set_mask(set_mask), .clr_mask(clr_mask), .hirq(hirq)
);

// File: tb/dbell_msg_unit_test.sv
module dbell_msg_unit_test;
  localparam int N = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flavour = 1'b0;
  logic        snd_vld = 1'b0;
  logic [31:0] snd_word = '0;
  logic        clr_vld = 1'b0;
  logic [31:0] clr_word = '0;
  logic [1:0]  clr_cpu = '0;
  logic [79:0] proc_ids = {20'h3FFFF, 20'h00123, 20'h40005, 20'h00005};
  logic [11:0] set_mask;
  logic [11:0] clr_mask;
  logic [3:0]  hirq;

  int vectors = 0;
  int misses = 0;

  always #10 clk = ~clk;

  dbell_msg_unit #(.NPROC(N)) uut (
    .clk(clk), .rst_n(rst_n), .flavour(flavour), .snd_vld(snd_vld), .snd_word(snd_word),
    .clr_vld(clr_vld), .clr_word(clr_word), .clr_cpu(clr_cpu), .proc_ids(proc_ids),
    .set_mask(set_mask), .clr_mask(clr_mask), .hirq(hirq)
  );

  function automatic logic [2:0] ref_kind(input logic f, input logic [31:0] w);
    int t = int'(w[31:27]);
    if (f) return (t == 5) ? 3'b100 : 3'b000;
    if (t == 0) return 3'b001;
    if (t == 1) return 3'b010;
    return 3'b000;
  endfunction

  function automatic logic ref_hit(input logic f, input logic [31:0] w, input logic [19:0] id);
    if (f) return w[19:0] == id;
    return w[26] || (w[13:0] % 16384) == (id % 16384);
  endfunction

  task automatic check(input string req, input logic [11:0] es, input logic [11:0] ec,
                       input logic [3:0] ei);
    vectors++;
    if (set_mask !== es || clr_mask !== ec || hirq !== ei) begin
      misses++;
      $display("FAIL %s: set=%h clr=%h irq=%h expected set=%h clr=%h irq=%h",
               req, set_mask, clr_mask, hirq, es, ec, ei);
    end
  endtask

  task automatic apply(input string req, input logic f, input logic sv, input logic [31:0] sw,
                       input logic cv, input logic [31:0] cw, input logic [1:0] cc);
    logic [11:0] es, ec;
    logic [3:0] ei;
    logic [2:0] sk, ck;
    es = '0; ec = '0; ei = '0;
    sk = sv ? ref_kind(f, sw) : 3'b000;
    ck = cv ? ref_kind(f, cw) : 3'b000;
    for (int p = 0; p < N; p++) begin
      if (ref_hit(f, sw, proc_ids[p*20 +: 20]) && sk != 0) begin
        es[p*3 +: 3] = sk;
        ei[p] = 1'b1;
      end
    end
    ec[int'(cc)*3 +: 3] = ck & ~es[int'(cc)*3 +: 3];
    @(negedge clk);
    flavour = f; snd_vld = sv; snd_word = sw; clr_vld = cv; clr_word = cw; clr_cpu = cc;
    @(negedge clk);
    snd_vld = 1'b0; clr_vld = 1'b0;
    check(req, es, ec, ei);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    misses++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    logic [19:0] tags [6] = '{20'h00005, 20'h40005, 20'h00123, 20'h3FFFF, 20'h03FFF, 20'h00077};
    repeat (3) @(negedge clk);
    check("R1 in reset", '0, '0, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", '0, '0, '0);

    // Sends: R2 R3 R5 in embedded, R4 R6 in server, R8 strobes throughout
    for (int f = 0; f < 2; f++)
      for (int t = 0; t < 32; t++)
        for (int b = 0; b < 2; b++)
          for (int g = 0; g < 6; g++)
            apply(f ? "R4/R6/R8 server send" : "R2/R3/R5/R8 embedded send", f[0], 1'b1,
                  {t[4:0], b[0], 6'h2A, tags[g]}, 1'b0, '0, 2'd0);

    // Clears: R7 on every slot, types and flavours
    for (int f = 0; f < 2; f++)
      for (int t = 0; t < 32; t++)
        for (int c = 0; c < 4; c++)
          apply("R7 clear", f[0], 1'b0, '0, 1'b1, {t[4:0], 1'b1, 26'h0000005}, c[1:0]);

    // R10 collisions and non-colliding pairs
    apply("R10 embedded collide", 1'b0, 1'b1, {5'd0, 1'b1, 26'h0}, 1'b1, {5'd0, 27'h0}, 2'd2);
    apply("R10 embedded other slot", 1'b0, 1'b1, {5'd1, 1'b0, 26'h00123}, 1'b1, {5'd1, 27'h0}, 2'd3);
    apply("R10 embedded other kind", 1'b0, 1'b1, {5'd1, 1'b0, 26'h00005}, 1'b1, {5'd0, 27'h0}, 2'd1);
    apply("R10 server collide", 1'b1, 1'b1, {5'd5, 1'b0, 26'h00123}, 1'b1, {5'd5, 27'h0}, 2'd2);

    // R9: one-cycle pulse, quiet afterwards
    @(negedge clk);
    check("R9 idle", '0, '0, '0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule